// File: doc/BRIEF.md
# Regulator Fault Supervisor with Hiccup Restart

This block is the digital protection controller of a synchronous buck regulator. It watches the overcurrent comparators on both power switches, an output undervoltage comparator and a pair of junction temperature comparators. From these it decides three things. It cuts the high-side switch for the rest of a switching cycle. It shuts the regulator down on a persistent fault. It runs a timed hiccup retry that waits a fixed number of soft-start periods before it asks for a fresh soft-start.

Time is counted in switching cycles, each one opened by a one-clock `cycle_tick`, and in soft-start periods, each one closed by a one-clock `ss_done` pulse. Overcurrent flags count only after a minimum on-time window that follows each tick. A cycle that holds at least one counted overcurrent adds one to a run-length counter. Eight such cycles in a row cause a shutdown. The undervoltage check is gated by that counter. Over-temperature takes priority over all other conditions. It keeps the regulator off without pulling the enable line low.

Top module: `buck_fault_supervisor`

## Requirements
- R1: During reset, and in the first clock after reset, `run`, `hs_kill`, `en_pull_low` and `ss_restart` are all 0. With `en_in` high the block raises `ss_restart` for exactly one clock, then holds `run` high.
- R2: An overcurrent flag counts only once BLANK_CLKS (default 4) rising clock edges have passed since the edge that sampled `cycle_tick`. A flag earlier in the cycle, or on a tick clock, has no effect on `hs_kill` or on the counter.
- R3: A counted overcurrent sets `hs_kill` on the next clock. `hs_kill` stays high until the next `cycle_tick` clears it.
- R4: An overcurrent on the high-side flag `oc_hi` and one on the low-side flag `oc_lo` are treated the same.
- R5: The first counted overcurrent of a cycle adds one to the run-length counter and raises an internal overcurrent flag. Reaching OC_LIMIT (default 8) consecutive cycles drops `run` and raises `en_pull_low` on the next clock.
- R6: A cycle with no counted overcurrent clears the counter and the flag when the next tick is sampled. Seven overcurrent cycles, one clean cycle and seven more do not cause a shutdown.
- R7: Undervoltage while the overcurrent flag is low shuts the regulator down on the next clock, with `en_pull_low` high.
- R8: Undervoltage while the flag is high and the counter is below UV_GATE (default 4) also shuts the regulator down. With the counter at UV_GATE or above, undervoltage is ignored and `run` stays high.
- R9: After a fault shutdown, `en_pull_low` stays high and `run` stays low until the WAIT_PERIODS-th (default 4) `ss_done` pulse. On the clock after that pulse, the pull-down is released, the counters are clear and `ss_restart` pulses for one clock, followed by `run`.
- R10: `thermal_hot` drops `run` on the next clock and does not pull enable low. The block stays off until `thermal_cool` has been seen, then restarts through `ss_restart`.
- R11: `en_in` low while running drops `run` on the next clock without pulling enable low. `en_in` high again starts a restart.
- R12: Over-temperature during the hiccup wait releases `en_pull_low` on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_tick | input | 1 | One-clock pulse at the start of each switching cycle |
| oc_hi | input | 1 | High-side switch overcurrent comparator |
| oc_lo | input | 1 | Low-side switch overcurrent comparator |
| uv_flag | input | 1 | Feedback below 80 % of reference |
| thermal_hot | input | 1 | Junction at or above the trip temperature |
| thermal_cool | input | 1 | Junction below the recovery temperature |
| ss_done | input | 1 | One-clock pulse at the end of each soft-start period |
| en_in | input | 1 | Level sensed on the external enable line |
| hs_kill | output | 1 | Force the high-side switch off for the rest of the cycle |
| run | output | 1 | Regulator switching allowed |
| en_pull_low | output | 1 | Drive the enable line low during a fault wait |
| ss_restart | output | 1 | One-clock request to start a new soft-start ramp |

## Verification
A run-length counter that is off by one shows at the ports within one switching cycle of the eighth overcurrent: the shutdown comes a cycle early or a cycle late. A wrong counter also makes undervoltage near a count of four either trip or be ignored, against the rule. A blanking window of the wrong length shows as `hs_kill` rising on an early flag, or missing a late one, within the same cycle. A wrong soft-start wait count or a stuck thermal latch shows as `en_pull_low` or `run` at the wrong level on the clock after the relevant `ss_done` or temperature flag. The bench compares all four outputs against an independent model on every clock, so any divergence is caught within one clock.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RESTART = 3'd1,
    ST_RUN     = 3'd2,
    ST_FWAIT   = 3'd3,
    ST_THERM   = 3'd4
  } sup_state_t;
endpackage

// File: rtl/sup_blank.sv
// Minimum on-time window: opens BLANK_CLKS edges after the tick edge.
module sup_blank #(
  parameter int BLANK_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_tick,
  output logic win_open
);
  localparam int BW = $clog2(BLANK_CLKS + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CLKS);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = cycle_tick | (cnt_q != BLANK_END);
    cnt_d  = cycle_tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign win_open = (cnt_q == BLANK_END);
endmodule

// File: rtl/sup_oc_track.sv
// Per-cycle overcurrent kill, consecutive-cycle counter, undervoltage gate.
module sup_oc_track #(
  parameter int OC_LIMIT = 8,
  parameter int UV_GATE  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_tick,
  input  logic win_open,
  input  logic run,
  input  logic oc_hi,
  input  logic oc_lo,
  input  logic uv_flag,
  output logic hs_kill,
  output logic oc_shut,
  output logic uv_trip
);
  localparam int CW = $clog2(OC_LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(OC_LIMIT);
  localparam logic [CW-1:0] CNT_LAST = CW'(OC_LIMIT - 1);
  localparam logic [CW-1:0] CNT_GATE = CW'(UV_GATE);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          cyc_q, cyc_d;
  logic          kill_q, kill_d;
  logic          trk_en, kill_en;
  logic          oc_valid;

  assign oc_valid = run & win_open & ~cycle_tick & (oc_hi | oc_lo);

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    cyc_d  = cyc_q;
    trk_en = 1'b0;
    if (!run) begin
      trk_en = 1'b1;
      cnt_d  = '0;
      flag_d = 1'b0;
      cyc_d  = 1'b0;
    end else if (cycle_tick) begin
      trk_en = 1'b1;
      cyc_d  = 1'b0;
      if (!cyc_q) begin
        cnt_d  = '0;
        flag_d = 1'b0;
      end
    end else if (oc_valid && !cyc_q) begin
      trk_en = 1'b1;
      cyc_d  = 1'b1;
      flag_d = 1'b1;
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    kill_en = cycle_tick | oc_valid;
    kill_d  = ~cycle_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      cyc_q  <= 1'b0;
    end else if (trk_en) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      cyc_q  <= cyc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kill_q <= 1'b0;
    else if (kill_en) kill_q <= kill_d;
  end

  assign hs_kill = kill_q;
  assign oc_shut = oc_valid & ~cyc_q & (cnt_q == CNT_LAST);
  assign uv_trip = run & uv_flag & (~flag_q | (cnt_q < CNT_GATE));
endmodule

// File: rtl/sup_thermal.sv
// Hysteretic over-temperature latch; active as soon as the hot flag is seen.
module sup_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic thermal_hot,
  input  logic thermal_cool,
  output logic therm_active
);
  logic hot_q, hot_d, hot_en;

  always_comb begin
    hot_en = thermal_hot | thermal_cool;
    hot_d  = thermal_hot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hot_q <= 1'b0;
    else if (hot_en) hot_q <= hot_d;
  end

  assign therm_active = thermal_hot | hot_q;
endmodule

// File: rtl/sup_hiccup.sv
// Run / fault-wait / restart sequencer counting soft-start periods.
module sup_hiccup
  import sup_pkg::*;
#(
  parameter int WAIT_PERIODS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  input  logic therm_active,
  input  logic oc_shut,
  input  logic uv_trip,
  input  logic ss_done,
  output logic run,
  output logic en_pull_low,
  output logic ss_restart
);
  localparam int WW = $clog2(WAIT_PERIODS + 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(WAIT_PERIODS - 1);

  sup_state_t    st_q, st_d;
  logic [WW-1:0] ss_q, ss_d;
  logic          ss_en;

  always_comb begin
    st_d  = st_q;
    ss_d  = ss_q;
    ss_en = 1'b0;
    if (therm_active) begin
      st_d = ST_THERM;
    end else begin
      case (st_q)
        ST_IDLE:    if (en_in) st_d = ST_RESTART;
        ST_RESTART: st_d = ST_RUN;
        ST_RUN: begin
          if (oc_shut || uv_trip) begin
            st_d  = ST_FWAIT;
            ss_d  = '0;
            ss_en = 1'b1;
          end else if (!en_in) begin
            st_d = ST_IDLE;
          end
        end
        ST_FWAIT: begin
          if (ss_done) begin
            if (ss_q == WAIT_LAST) begin
              st_d = ST_RESTART;
            end else begin
              ss_d  = ss_q + 1'b1;
              ss_en = 1'b1;
            end
          end
        end
        ST_THERM:   st_d = en_in ? ST_RESTART : ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ss_q <= '0;
    else if (ss_en) ss_q <= ss_d;
  end

  assign run         = (st_q == ST_RUN);
  assign en_pull_low = (st_q == ST_FWAIT);
  assign ss_restart  = (st_q == ST_RESTART);
endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor #(
  parameter int BLANK_CLKS   = 4,
  parameter int OC_LIMIT     = 8,
  parameter int UV_GATE      = 4,
  parameter int WAIT_PERIODS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_tick,
  input  logic oc_hi,
  input  logic oc_lo,
  input  logic uv_flag,
  input  logic thermal_hot,
  input  logic thermal_cool,
  input  logic ss_done,
  input  logic en_in,
  output logic hs_kill,
  output logic run,
  output logic en_pull_low,
  output logic ss_restart
);
  logic win_open;
  logic oc_shut;
  logic uv_trip;
  logic therm_active;

  sup_blank #(.BLANK_CLKS(BLANK_CLKS)) u_blank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_tick (cycle_tick),
    .win_open   (win_open)
  );

  sup_oc_track #(.OC_LIMIT(OC_LIMIT), .UV_GATE(UV_GATE)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_tick (cycle_tick),
    .win_open   (win_open),
    .run        (run),
    .oc_hi      (oc_hi),
    .oc_lo      (oc_lo),
    .uv_flag    (uv_flag),
    .hs_kill    (hs_kill),
    .oc_shut    (oc_shut),
    .uv_trip    (uv_trip)
  );

  sup_thermal u_therm (
    .clk          (clk),
    .rst_n        (rst_n),
    .thermal_hot  (thermal_hot),
    .thermal_cool (thermal_cool),
    .therm_active (therm_active)
  );

  sup_hiccup #(.WAIT_PERIODS(WAIT_PERIODS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_in        (en_in),
    .therm_active (therm_active),
    .oc_shut      (oc_shut),
    .uv_trip      (uv_trip),
    .ss_done      (ss_done),
    .run          (run),
    .en_pull_low  (en_pull_low),
    .ss_restart   (ss_restart)
  );
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic clk,
  input logic rst_n,
  input logic cycle_tick,
  input logic oc_hi,
  input logic oc_lo,
  input logic uv_flag,
  input logic thermal_hot,
  input logic thermal_cool,
  input logic ss_done,
  input logic en_in,
  input logic hs_kill,
  input logic run,
  input logic en_pull_low,
  input logic ss_restart
);
  // R9
  pull_excl_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_pull_low |-> !run);

  // R3
  kill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_kill) |-> $past(cycle_tick));

  // R4
  kill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_kill) |-> ($past(oc_hi || oc_lo) && $past(run)));

  // R1
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);

  // R10
  therm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_hot |=> (!run && !en_pull_low));

  // R5
  wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_pull_low) |-> $past(run));

  // R11
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !en_in) |=> !run);
endmodule

bind buck_fault_supervisor sup_checker i_sup_checker (.*);

// File: tb/test_buck_fault_supervisor.sv
module test_buck_fault_supervisor;
  localparam int BLANK = 4;
  localparam int LIMIT = 8;
  localparam int GATE  = 4;
  localparam int WAITN = 4;
  localparam int CYC   = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cycle_tick, oc_hi, oc_lo, uv_flag, thermal_hot, thermal_cool, ss_done, en_in;
  logic hs_kill, run, en_pull_low, ss_restart;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  buck_fault_supervisor i_buck_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick), .oc_hi(oc_hi), .oc_lo(oc_lo),
    .uv_flag(uv_flag), .thermal_hot(thermal_hot), .thermal_cool(thermal_cool),
    .ss_done(ss_done), .en_in(en_in), .hs_kill(hs_kill), .run(run),
    .en_pull_low(en_pull_low), .ss_restart(ss_restart)
  );

  // Reference model written from the requirements. 0 idle,1 restart,2 run,3 wait,4 thermal
  int m_st, m_blank, m_cnt, m_ss;
  bit m_kill, m_flag, m_cyc, m_hot;

  function automatic bit exp_run();     return m_st == 2; endfunction
  function automatic bit exp_pull();    return m_st == 3; endfunction
  function automatic bit exp_restart(); return m_st == 1; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_blank = 0; m_cnt = 0; m_ss = 0;
      m_kill = 0; m_flag = 0; m_cyc = 0; m_hot = 0;
    end else begin
      bit therm, ocv, shut, uvt, running;
      therm   = thermal_hot | m_hot;
      running = (m_st == 2);
      ocv     = running && (m_blank == BLANK) && !cycle_tick && (oc_hi || oc_lo);
      shut    = ocv && !m_cyc && (m_cnt == LIMIT - 1);
      uvt     = running && uv_flag && (!m_flag || m_cnt < GATE);
      if (cycle_tick) m_kill = 0; else if (ocv) m_kill = 1;
      if (!running) begin m_cnt = 0; m_flag = 0; m_cyc = 0; end
      else if (cycle_tick) begin
        if (!m_cyc) begin m_cnt = 0; m_flag = 0; end
        m_cyc = 0;
      end else if (ocv && !m_cyc) begin
        m_cyc = 1; m_flag = 1; if (m_cnt < LIMIT) m_cnt++;
      end
      if (cycle_tick) m_blank = 0; else if (m_blank != BLANK) m_blank++;
      if (thermal_hot) m_hot = 1; else if (thermal_cool) m_hot = 0;
      if (therm) m_st = 4;
      else case (m_st)
        0: if (en_in) m_st = 1;
        1: m_st = 2;
        2: if (shut || uvt) begin m_st = 3; m_ss = 0; end else if (!en_in) m_st = 0;
        3: if (ss_done) begin if (m_ss == WAITN - 1) m_st = 1; else m_ss++; end
        default: m_st = en_in ? 1 : 0;
      endcase
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    check("R3 model hs_kill", hs_kill, m_kill);
    check("R5 model run", run, exp_run());
    check("R9 model en_pull_low", en_pull_low, exp_pull());
    check("R1 model ss_restart", ss_restart, exp_restart());
  end

  task automatic idle_inputs();
    cycle_tick = 0; oc_hi = 0; oc_lo = 0; uv_flag = 0;
    thermal_hot = 0; thermal_cool = 0; ss_done = 0;
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One switching cycle: tick, optional early undervoltage, overcurrent at clock 6.
  task automatic sw_cycle(input bit oc, input bit use_lo, input bit uv_early);
    cycle_tick = 1; clocks(1);
    cycle_tick = 0; uv_flag = uv_early; clocks(1);
    uv_flag = 0; clocks(4);
    oc_hi = oc & ~use_lo; oc_lo = oc & use_lo; clocks(1);
    oc_hi = 0; oc_lo = 0; clocks(CYC - 7);
  endtask

  task automatic ss_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ss_done = 1; clocks(1); ss_done = 0; clocks(2);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7215);
    idle_inputs(); en_in = 1; rst_n = 0;
    clocks(3);
    check("R1 reset run", run, 1'b0);
    check("R1 reset pull", en_pull_low, 1'b0);
    check("R1 reset kill", hs_kill, 1'b0);
    rst_n = 1; cmp_en = 1;
    clocks(1);
    check("R1 restart pulse", ss_restart, 1'b1);
    clocks(1);
    check("R1 run after restart", run, 1'b1);
    clocks(3);

    // R2: early flag in the blanking window is ignored
    cycle_tick = 1; clocks(1); cycle_tick = 0; oc_hi = 1; clocks(2); oc_hi = 0;
    check("R2 early oc ignored", hs_kill, 1'b0);
    clocks(6);
    // R3 / R4: low-side flag after window kills until next tick
    sw_cycle(1'b1, 1'b1, 1'b0);
    check("R4 low-side kill held", hs_kill, 1'b1);
    cycle_tick = 1; clocks(1); cycle_tick = 0; clocks(1);
    check("R3 kill cleared by tick", hs_kill, 1'b0);
    clocks(8);
    sw_cycle(1'b0, 1'b0, 1'b0);
    sw_cycle(1'b0, 1'b0, 1'b0);

    // R6: a clean cycle resets the run length
    for (int i = 0; i < 7; i++) sw_cycle(1'b1, i[0], 1'b0);
    sw_cycle(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) sw_cycle(1'b1, 1'b0, 1'b0);
    check("R6 no shutdown after split runs", run, 1'b1);
    sw_cycle(1'b0, 1'b0, 1'b0);

    // R5: eight in a row
    for (int i = 0; i < 8; i++) sw_cycle(1'b1, 1'b0, 1'b0);
    check("R5 shutdown run", run, 1'b0);
    check("R5 shutdown pull", en_pull_low, 1'b1);

    // R9: hiccup wait
    ss_pulses(3);
    check("R9 still waiting", en_pull_low, 1'b1);
    ss_done = 1; clocks(1); ss_done = 0;
    check("R9 restart pulse", ss_restart, 1'b1);
    clocks(1);
    check("R9 run again", run, 1'b1);
    check("R9 pull released", en_pull_low, 1'b0);
    clocks(3);

    // R7: undervoltage with no overcurrent
    sw_cycle(1'b0, 1'b0, 1'b1);
    check("R7 uv shutdown", en_pull_low, 1'b1);
    ss_pulses(4); clocks(2);
    check("R7 recovered", run, 1'b1);

    // R8: undervoltage with count below gate trips
    sw_cycle(1'b1, 1'b0, 1'b0);
    sw_cycle(1'b1, 1'b0, 1'b0);
    sw_cycle(1'b0, 1'b0, 1'b1);
    check("R8 uv below gate trips", en_pull_low, 1'b1);
    ss_pulses(4); clocks(2);
    // R8: count at or above gate ignores undervoltage
    for (int i = 0; i < 5; i++) sw_cycle(1'b1, 1'b0, 1'b0);
    sw_cycle(1'b1, 1'b0, 1'b1);
    check("R8 uv above gate ignored", run, 1'b1);
    sw_cycle(1'b0, 1'b0, 1'b0);
    sw_cycle(1'b0, 1'b0, 1'b0);

    // R10: thermal trip with hysteresis
    thermal_hot = 1; clocks(1); thermal_hot = 0;
    check("R10 thermal off run", run, 1'b0);
    check("R10 thermal no pull", en_pull_low, 1'b0);
    clocks(6);
    check("R10 held until cool", run, 1'b0);
    thermal_cool = 1; clocks(1); thermal_cool = 0; clocks(3);
    check("R10 restarted after cool", run, 1'b1);

    // R12: thermal during fault wait releases pull-down
    sw_cycle(1'b0, 1'b0, 1'b1);
    check("R12 in fault wait", en_pull_low, 1'b1);
    thermal_hot = 1; clocks(1); thermal_hot = 0;
    check("R12 pull released", en_pull_low, 1'b0);
    thermal_cool = 1; clocks(1); thermal_cool = 0; clocks(3);

    // R11: enable level
    en_in = 0; clocks(1);
    check("R11 disabled run", run, 1'b0);
    check("R11 disabled no pull", en_pull_low, 1'b0);
    en_in = 1; clocks(3);
    check("R11 re-enabled", run, 1'b1);

    // Random phase, checked against the model every clock
    begin
      int ph = 0;
      int per = CYC;
      for (int k = 0; k < 40000; k++) begin
        cycle_tick  = (ph == 0);
        oc_hi       = ($urandom % 5) == 0;
        oc_lo       = ($urandom % 9) == 0;
        uv_flag     = ($urandom % 90) == 0;
        thermal_hot = ($urandom % 1500) == 0;
        thermal_cool= !thermal_hot && (($urandom % 6) == 0);
        ss_done     = ($urandom % 12) == 0;
        en_in       = ($urandom % 400) != 0;
        ph++;
        if (ph >= per) begin ph = 0; per = 8 + ($urandom % 6); end
        clocks(1);
      end
    end
    idle_inputs(); en_in = 1; clocks(4);
    cmp_en = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule